// File: doc/BRIEF.md
# Lane Receive Elastic Buffer

This block sits on one receive lane behind the 8b/10b decoder. Every cycle of the lane's recovered clock it takes one 4-byte decoded word. With each word come a per-byte control-character flag and four alignment-detect flags. It hands the data and control flags to the fabric system clock through a 24-entry store, 36 bits per entry. The alignment-detect flags steer arming only and are never stored. The same store is the skew absorber when several lanes are deskewed together by an outside group controller.

Both pointers stay parked until the buffer is armed. Before that, incoming words are dropped and the read side shows no valid data. The arming event depends on `group_mode`. In stand-alone operation it is the first word whose top alignment-detect flag is set. In group operation it is a load strobe from the group controller. On arming, that word goes to entry 0 and reading starts at entry 12, which gives a half-depth margin for lane skew and clock crossing. The write side raises a sticky overflow flag when the free space it sees falls below a programmable minimum. The read side raises a sticky underflow flag when its pointer meets the write pointer. A resync pulse returns the block to the unarmed state.

The write side has two states. It goes from W_IDLE to W_LIVE on an arming event and from W_LIVE back to W_IDLE on resync. The read side has three states. It goes from R_IDLE to R_PRIME once it sees the armed indication, from R_PRIME to R_RUN when its pointer wraps from entry 23 to entry 0, and from any state back to R_IDLE when the armed indication drops. Each pointer counts modulo 24. It crosses to the other clock domain as a cyclic code in which one bit changes per step, through a two-flop synchroniser.

Top module: `lane_efifo`

## Requirements
- R1: Each stored entry keeps the 32 data bits (`wr_data`) and the 4 control flags (`wr_ctrl`, bit i belonging to byte i). After arming, words leave on `rd_data`/`rd_ctrl` unchanged and in write order, one per read cycle, including across the wrap from entry 23 to entry 0.
- R2: Alignment-detect flags are not stored. A word with any of `wr_align[2:0]` set but `wr_align[3]` clear does not arm the buffer, so `rd_valid` stays 0.
- R3: In stand-alone mode (`group_mode`=0), the first word with `wr_align[3]`=1 after reset or resync arms the buffer. That word is written to entry 0, the read pointer starts at entry 12, and the marker word is the first word presented with `rd_valid`=1. Words before it are discarded.
- R4: After the read side sees the armed indication it passes through R_PRIME, stepping entries 12 to 23 with `rd_valid`=0. `rd_valid` rises only when entry 0 is read, at least 12 read cycles after arming.
- R5: While armed, `overflow` is set when DEPTH − ((write pointer − observed read pointer) mod DEPTH) is less than `ovfl_min`. Once set it stays set, whatever `ovfl_min` does later, until resync or reset.
- R6: `underflow` is set when, in R_PRIME or R_RUN, the synchronised write pointer equals the read pointer. It stays set until the read side returns to R_IDLE.
- R7: Between consecutive cycles of the armed state, each pointer's crossing code changes in at most one bit.
- R8: With `group_mode`=1, `wr_align[3]` is ignored for arming. A `grp_load` pulse arms the buffer as in R3, and the word written in that cycle is the first valid output.
- R9: A `resync` pulse returns the write side to W_IDLE and clears `overflow`. The read side then returns to R_IDLE, dropping `rd_valid` and clearing `underflow`. The next arming event re-arms the buffer as in R3.
- R10: After reset `rd_valid`, `overflow` and `underflow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Lane recovered receive clock |
| wr_rst_n | input | 1 | Asynchronous active-low reset, write domain |
| wr_data | input | 32 | Decoded data bytes |
| wr_ctrl | input | 4 | Per-byte control-character flags |
| wr_align | input | 4 | Alignment-detect flags; bit 3 is the arming marker |
| resync | input | 1 | Write-domain pulse that disarms the buffer |
| group_mode | input | 1 | 1: arming comes from `grp_load` |
| grp_load | input | 1 | Write-domain arming strobe from the group controller |
| ovfl_min | input | 5 | Minimum free entries before overflow |
| overflow | output | 1 | Sticky overflow flag, write domain |
| rd_clk | input | 1 | Fabric system clock |
| rd_rst_n | input | 1 | Asynchronous active-low reset, read domain |
| rd_data | output | 32 | Data bytes out |
| rd_ctrl | output | 4 | Control flags out |
| rd_valid | output | 1 | Output word is valid |
| underflow | output | 1 | Sticky underflow flag, read domain |

## Verification
The properties assume the write-domain strobes `resync`, `grp_load` and the arming marker are driven synchronously to `wr_clk`. They also assume `group_mode` changes only while the buffer is unarmed, and that both resets are applied together. The bench drives every write-domain input from one loop clocked on the falling edge of `wr_clk`. It changes `group_mode` only after a resync has settled, and it releases both resets at the same time. The two clocks run at the same nominal rate with a phase offset. The write clock is halted only to force underflow and is restarted before any resync is issued.

// File: rtl/lane_efifo_pkg.sv
package lane_efifo_pkg;

    typedef enum logic [0:0] {
        W_IDLE,
        W_LIVE
    } wr_state_t;

    typedef enum logic [1:0] {
        R_IDLE,
        R_PRIME,
        R_RUN
    } rd_state_t;

    // Cyclic single-bit-change code for an even ring length: a window of a
    // reflected binary code, centred so that the last and first states differ
    // only in the top bit.
    function automatic int ring_code(input int idx, input int off);
        int v;
        v = idx + off;
        return v ^ (v >> 1);
    endfunction

endpackage

// File: rtl/lane_efifo_sync.sv
module lane_efifo_sync #(
    parameter int          W       = 5,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/lane_efifo_dec.sv
module lane_efifo_dec #(
    parameter int DEPTH = 24,
    localparam int PW   = $clog2(DEPTH),
    localparam int OFF  = ((1 << PW) - DEPTH) / 2
) (
    input  logic [PW-1:0] code,
    output logic [PW-1:0] bin
);

    logic [PW-1:0] raw;

    always_comb begin
        raw[PW-1] = code[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            raw[i] = raw[i+1] ^ code[i];
        end
        bin = raw - PW'(OFF);
    end

endmodule

// File: rtl/lane_efifo_ram.sv
module lane_efifo_ram #(
    parameter int DEPTH = 24,
    parameter int W     = 36,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [PW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          re,
    input  logic [PW-1:0] raddr,
    output logic [W-1:0]  q
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n)  q <= '0;
        else if (re)    q <= mem[raddr];
    end

endmodule

// File: rtl/lane_efifo_wr.sv
module lane_efifo_wr
    import lane_efifo_pkg::*;
#(
    parameter int DEPTH = 24,
    localparam int PW   = $clog2(DEPTH),
    localparam int OFF  = ((1 << PW) - DEPTH) / 2
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic          resync,
    input  logic          group_mode,
    input  logic          grp_load,
    input  logic          align_msb,
    input  logic [PW-1:0] ovfl_min,
    input  logic [PW-1:0] rptr_seen,
    output logic          mem_we,
    output logic [PW-1:0] mem_waddr,
    output logic          armed,
    output logic [PW-1:0] wptr,
    output logic [PW-1:0] wcode,
    output logic          overflow
);

    wr_state_t     state_q, state_d;
    logic [PW-1:0] wptr_d;
    logic          ovfl_d;
    logic          arm_cmd;
    logic [PW:0]   used;
    logic [PW:0]   free_cnt;

    assign arm_cmd = group_mode ? grp_load : align_msb;

    // Entries in flight as seen from the write side.
    always_comb begin
        if (wptr >= rptr_seen) used = {1'b0, wptr} - {1'b0, rptr_seen};
        else                   used = {1'b0, wptr} + (PW+1)'(DEPTH) - {1'b0, rptr_seen};
        free_cnt = (PW+1)'(DEPTH) - used;
    end

    // State register
    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) begin
            state_q  <= W_IDLE;
            wptr     <= '0;
            wcode    <= PW'(ring_code(0, OFF));
            overflow <= 1'b0;
        end else begin
            state_q  <= state_d;
            wptr     <= wptr_d;
            wcode    <= PW'(ring_code(int'(wptr_d), OFF));
            overflow <= ovfl_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d   = state_q;
        wptr_d    = wptr;
        ovfl_d    = overflow;
        mem_we    = 1'b0;
        mem_waddr = wptr;
        if (resync) begin
            state_d = W_IDLE;
            wptr_d  = '0;
            ovfl_d  = 1'b0;
        end else begin
            unique case (state_q)
                W_IDLE: begin
                    if (arm_cmd) begin
                        state_d   = W_LIVE;
                        mem_we    = 1'b1;
                        mem_waddr = '0;
                        wptr_d    = PW'(1);
                    end
                end
                W_LIVE: begin
                    mem_we    = 1'b1;
                    mem_waddr = wptr;
                    wptr_d    = (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
                    if (free_cnt < {1'b0, ovfl_min}) ovfl_d = 1'b1;
                end
                default: state_d = W_IDLE;
            endcase
        end
    end

    assign armed = (state_q == W_LIVE);

endmodule

// File: rtl/lane_efifo_rd.sv
module lane_efifo_rd
    import lane_efifo_pkg::*;
#(
    parameter int DEPTH = 24,
    localparam int PW   = $clog2(DEPTH),
    localparam int OFF  = ((1 << PW) - DEPTH) / 2,
    localparam int MID  = DEPTH / 2
) (
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          armed_seen,
    input  logic [PW-1:0] wptr_seen,
    output logic          mem_re,
    output logic [PW-1:0] mem_raddr,
    output logic          rd_valid,
    output logic [PW-1:0] rptr,
    output logic [PW-1:0] rcode,
    output logic          idle,
    output logic          underflow
);

    rd_state_t     state_q, state_d;
    logic [PW-1:0] rptr_d;
    logic          valid_d;
    logic          uflow_d;
    logic [PW-1:0] rptr_step;

    assign rptr_step = (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;

    // State register
    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
            state_q   <= R_IDLE;
            rptr      <= PW'(MID);
            rcode     <= PW'(ring_code(MID, OFF));
            rd_valid  <= 1'b0;
            underflow <= 1'b0;
        end else begin
            state_q   <= state_d;
            rptr      <= rptr_d;
            rcode     <= PW'(ring_code(int'(rptr_d), OFF));
            rd_valid  <= valid_d;
            underflow <= uflow_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d   = state_q;
        rptr_d    = rptr;
        valid_d   = 1'b0;
        uflow_d   = underflow;
        mem_re    = 1'b0;
        mem_raddr = rptr;
        if (!armed_seen) begin
            state_d = R_IDLE;
            rptr_d  = PW'(MID);
            uflow_d = 1'b0;
        end else begin
            unique case (state_q)
                R_IDLE: begin
                    state_d = R_PRIME;
                end
                R_PRIME: begin
                    rptr_d = rptr_step;
                    if (rptr == PW'(DEPTH - 1)) state_d = R_RUN;
                    if (wptr_seen == rptr)      uflow_d = 1'b1;
                end
                R_RUN: begin
                    mem_re  = 1'b1;
                    valid_d = 1'b1;
                    rptr_d  = rptr_step;
                    if (wptr_seen == rptr) uflow_d = 1'b1;
                end
                default: state_d = R_IDLE;
            endcase
        end
    end

    assign idle = (state_q == R_IDLE);

endmodule

// File: rtl/lane_efifo.sv
module lane_efifo
    import lane_efifo_pkg::*;
#(
    parameter int DEPTH       = 24,
    parameter int BYTES       = 4,
    parameter int SYNC_STAGES = 2,
    localparam int PW         = $clog2(DEPTH),
    localparam int DATA_W     = 8 * BYTES,
    localparam int WORD_W     = DATA_W + BYTES,
    localparam int MID        = DEPTH / 2,
    localparam int OFF        = ((1 << PW) - DEPTH) / 2
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BYTES-1:0]  wr_ctrl,
    input  logic [BYTES-1:0]  wr_align,
    input  logic              resync,
    input  logic              group_mode,
    input  logic              grp_load,
    input  logic [PW-1:0]     ovfl_min,
    output logic              overflow,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    output logic [DATA_W-1:0] rd_data,
    output logic [BYTES-1:0]  rd_ctrl,
    output logic              rd_valid,
    output logic              underflow
);

    localparam logic [PW-1:0] CODE_ZERO = PW'(ring_code(0, OFF));
    localparam logic [PW-1:0] CODE_MID  = PW'(ring_code(MID, OFF));

    logic              mem_we, mem_re;
    logic [PW-1:0]     mem_waddr, mem_raddr;
    logic [WORD_W-1:0] mem_q;
    logic              w_armed, r_armed_seen, r_idle;
    logic [PW-1:0]     w_ptr, w_code, r_ptr, r_code;
    logic [PW-1:0]     w_code_rd, r_code_wr;
    logic [PW-1:0]     w_ptr_rd, r_ptr_wr;
    logic              unused_align;

    assign unused_align = ^wr_align[BYTES-2:0];

    lane_efifo_wr #(.DEPTH(DEPTH)) u_wr (
        .wr_clk     (wr_clk),
        .wr_rst_n   (wr_rst_n),
        .resync     (resync),
        .group_mode (group_mode),
        .grp_load   (grp_load),
        .align_msb  (wr_align[BYTES-1]),
        .ovfl_min   (ovfl_min),
        .rptr_seen  (r_ptr_wr),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .armed      (w_armed),
        .wptr       (w_ptr),
        .wcode      (w_code),
        .overflow   (overflow)
    );

    lane_efifo_ram #(.DEPTH(DEPTH), .W(WORD_W)) u_ram (
        .wr_clk   (wr_clk),
        .we       (mem_we),
        .waddr    (mem_waddr),
        .wdata    ({wr_ctrl, wr_data}),
        .rd_clk   (rd_clk),
        .rd_rst_n (rd_rst_n),
        .re       (mem_re),
        .raddr    (mem_raddr),
        .q        (mem_q)
    );

    // Write domain -> read domain
    lane_efifo_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL(CODE_ZERO)) u_sync_wcode (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d     (w_code),
        .q     (w_code_rd)
    );

    lane_efifo_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_arm (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d     (w_armed),
        .q     (r_armed_seen)
    );

    // Read domain -> write domain
    lane_efifo_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL(CODE_MID)) u_sync_rcode (
        .clk   (wr_clk),
        .rst_n (wr_rst_n),
        .d     (r_code),
        .q     (r_code_wr)
    );

    lane_efifo_dec #(.DEPTH(DEPTH)) u_dec_w (
        .code (w_code_rd),
        .bin  (w_ptr_rd)
    );

    lane_efifo_dec #(.DEPTH(DEPTH)) u_dec_r (
        .code (r_code_wr),
        .bin  (r_ptr_wr)
    );

    lane_efifo_rd #(.DEPTH(DEPTH)) u_rd (
        .rd_clk     (rd_clk),
        .rd_rst_n   (rd_rst_n),
        .armed_seen (r_armed_seen),
        .wptr_seen  (w_ptr_rd),
        .mem_re     (mem_re),
        .mem_raddr  (mem_raddr),
        .rd_valid   (rd_valid),
        .rptr       (r_ptr),
        .rcode      (r_code),
        .idle       (r_idle),
        .underflow  (underflow)
    );

    assign rd_data = mem_q[DATA_W-1:0];
    assign rd_ctrl = mem_q[WORD_W-1:DATA_W];

endmodule

// File: rtl/lane_efifo_chk.sv
module lane_efifo_chk #(
    parameter int PW  = 5,
    parameter int MID = 12
) (
    input logic          wr_clk,
    input logic          wr_rst_n,
    input logic          rd_clk,
    input logic          rd_rst_n,
    input logic          resync,
    input logic          group_mode,
    input logic          grp_load,
    input logic          align_msb,
    input logic          w_armed,
    input logic [PW-1:0] w_ptr,
    input logic [PW-1:0] w_code,
    input logic          overflow,
    input logic          r_idle,
    input logic [PW-1:0] r_ptr,
    input logic [PW-1:0] r_code,
    input logic          r_armed_seen,
    input logic          underflow,
    input logic          rd_valid
);

    // R7: write pointer code moves by at most one bit while armed
    a_r7_wcode_one_bit: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (w_armed && $past(w_armed)) |-> ($countones(w_code ^ $past(w_code)) <= 1));

    // R7: read pointer code moves by at most one bit while active
    a_r7_rcode_one_bit: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (!r_idle && $past(!r_idle)) |-> ($countones(r_code ^ $past(r_code)) <= 1));

    // R3: a stand-alone marker arms and places the first word at entry 0
    a_r3_marker_arms: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (!w_armed && !resync && !group_mode && align_msb) |=> (w_armed && w_ptr == PW'(1)));

    // R3: an idle read side holds its pointer at mid-depth
    a_r3_read_mid: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        r_idle |-> (r_ptr == PW'(MID)));

    // R8: in group mode only the load strobe arms
    a_r8_group_ignores_marker: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (!w_armed && group_mode && !grp_load) |=> !w_armed);

    // R8: in group mode the load strobe arms at entry 0
    a_r8_group_load_arms: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (!w_armed && !resync && group_mode && grp_load) |=> (w_armed && w_ptr == PW'(1)));

    // R5: overflow is sticky until resync
    a_r5_overflow_sticky: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (overflow && !resync) |=> overflow);

    // R6: underflow is sticky while the read side stays armed
    a_r6_underflow_sticky: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (underflow && r_armed_seen) |=> underflow);

    // R4: valid output only follows a seen armed indication
    a_r4_valid_needs_arm: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_valid |-> $past(r_armed_seen));

    // R9: resync disarms and clears overflow
    a_r9_resync_clears: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        resync |=> (!w_armed && !overflow));

endmodule

bind lane_efifo lane_efifo_chk #(.PW(PW), .MID(MID)) u_chk (
    .wr_clk       (wr_clk),
    .wr_rst_n     (wr_rst_n),
    .rd_clk       (rd_clk),
    .rd_rst_n     (rd_rst_n),
    .resync       (resync),
    .group_mode   (group_mode),
    .grp_load     (grp_load),
    .align_msb    (wr_align[BYTES-1]),
    .w_armed      (w_armed),
    .w_ptr        (w_ptr),
    .w_code       (w_code),
    .overflow     (overflow),
    .r_idle       (r_idle),
    .r_ptr        (r_ptr),
    .r_code       (r_code),
    .r_armed_seen (r_armed_seen),
    .underflow    (underflow),
    .rd_valid     (rd_valid)
);

// File: tb/lane_efifo_bench.sv
`timescale 1ns/1ps
module lane_efifo_bench;

    localparam int DEPTH = 24;
    localparam int BYTES = 4;
    localparam int PW    = 5;

    logic        wr_clk = 1'b0;
    logic        rd_clk = 1'b0;
    logic        wr_run = 1'b1;
    logic        wr_rst_n = 1'b0;
    logic        rd_rst_n = 1'b0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_ctrl = '0;
    logic [3:0]  wr_align = '0;
    logic        resync = 1'b0;
    logic        group_mode = 1'b0;
    logic        grp_load = 1'b0;
    logic [PW-1:0] ovfl_min = PW'(2);
    logic        overflow;
    logic [31:0] rd_data;
    logic [3:0]  rd_ctrl;
    logic        rd_valid;
    logic        underflow;

    int n_chk  = 0;
    int n_fail = 0;
    int seq    = 0;
    int mark_seq = 0;
    bit mark_req = 0, low_req = 0, load_req = 0, resync_req = 0;

    lane_efifo #(.DEPTH(DEPTH), .BYTES(BYTES)) u_lane_efifo (
        .wr_clk     (wr_clk),
        .wr_rst_n   (wr_rst_n),
        .wr_data    (wr_data),
        .wr_ctrl    (wr_ctrl),
        .wr_align   (wr_align),
        .resync     (resync),
        .group_mode (group_mode),
        .grp_load   (grp_load),
        .ovfl_min   (ovfl_min),
        .overflow   (overflow),
        .rd_clk     (rd_clk),
        .rd_rst_n   (rd_rst_n),
        .rd_data    (rd_data),
        .rd_ctrl    (rd_ctrl),
        .rd_valid   (rd_valid),
        .underflow  (underflow)
    );

    // 200 MHz fabric clock; lane clock same rate, phase shifted, can be halted
    initial forever #2.5 rd_clk = ~rd_clk;
    initial begin
        #1.3;
        forever begin
            #2.5;
            if (wr_run) wr_clk = ~wr_clk;
        end
    end

    function automatic logic [31:0] pat(input int s);
        return {16'(s) ^ 16'hA5C3, 16'(s)};
    endfunction

    // Single driver of every lane-domain strobe
    initial begin
        forever begin
            @(negedge wr_clk);
            seq++;
            wr_data  = pat(seq);
            wr_ctrl  = 4'(seq);
            wr_align = '0;
            grp_load = 1'b0;
            resync   = 1'b0;
            if (mark_req)   begin wr_align[3] = 1'b1; mark_seq = seq; mark_req = 0; end
            if (low_req)    begin wr_align[2:0] = 3'b111; low_req = 0; end
            if (load_req)   begin grp_load = 1'b1; mark_seq = seq; load_req = 0; end
            if (resync_req) begin resync = 1'b1; resync_req = 0; end
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic rd_cycles(input int n);
        repeat (n) @(negedge rd_clk);
    endtask

    task automatic t_reset_state();
        check(rd_valid == 1'b0, "R10", "rd_valid after reset", rd_valid, 0);
        check(overflow == 1'b0, "R10", "overflow after reset", overflow, 0);
        check(underflow == 1'b0, "R10", "underflow after reset", underflow, 0);
    endtask

    task automatic t_low_flags_ignored();
        low_req = 1;
        wait (low_req == 0);
        rd_cycles(40);
        check(rd_valid == 1'b0, "R2", "low align flags must not arm", rd_valid, 0);
    endtask

    // Arms (marker or load) and checks the first word, latency and stream
    task automatic t_arm_stream(input string tag, input bit use_load);
        int lat;
        int bad;
        int first;
        if (use_load) begin load_req = 1; wait (load_req == 0); end
        else          begin mark_req = 1; wait (mark_req == 0); end
        first = mark_seq;
        lat = 0;
        while (!rd_valid && lat < 100) begin
            @(negedge rd_clk);
            lat++;
        end
        check(rd_valid == 1'b1, tag, "rd_valid rises after arming", rd_valid, 1);
        check(rd_data == pat(first), tag, "first valid word is arming word", rd_data, pat(first));
        check(rd_ctrl == 4'(first), "R1", "control flags of first word", rd_ctrl, 4'(first));
        check(lat >= 12 && lat <= 40, "R4", "cycles from arming to first valid", lat, 12);
        bad = 0;
        for (int k = 1; k <= 40; k++) begin
            @(negedge rd_clk);
            if (!rd_valid || rd_data != pat(first + k) || rd_ctrl != 4'(first + k)) bad++;
        end
        check(bad == 0, "R1", "in-order stream across wrap, mismatches", bad, 0);
    endtask

    task automatic t_resync();
        resync_req = 1;
        wait (resync_req == 0);
        rd_cycles(10);
        check(rd_valid == 1'b0, "R9", "rd_valid after resync", rd_valid, 0);
        check(overflow == 1'b0, "R9", "overflow after resync", overflow, 0);
        check(underflow == 1'b0, "R9", "underflow after resync", underflow, 0);
    endtask

    task automatic t_overflow();
        check(overflow == 1'b0, "R5", "no overflow with small minimum", overflow, 0);
        ovfl_min = PW'(12);
        rd_cycles(6);
        check(overflow == 1'b1, "R5", "overflow with large minimum", overflow, 1);
        ovfl_min = PW'(2);
        rd_cycles(10);
        check(overflow == 1'b1, "R5", "overflow stays set", overflow, 1);
    endtask

    task automatic t_underflow();
        check(underflow == 1'b0, "R6", "no underflow while lane runs", underflow, 0);
        wr_run = 1'b0;
        rd_cycles(40);
        check(underflow == 1'b1, "R6", "underflow with lane clock halted", underflow, 1);
        wr_run = 1'b1;
        rd_cycles(10);
        check(underflow == 1'b1, "R6", "underflow stays set", underflow, 1);
    endtask

    task automatic t_group();
        group_mode = 1'b1;
        mark_req = 1;
        wait (mark_req == 0);
        rd_cycles(40);
        check(rd_valid == 1'b0, "R8", "marker ignored in group mode", rd_valid, 0);
        t_arm_stream("R8", 1'b1);
    endtask

    initial begin
        wr_rst_n = 1'b0;
        rd_rst_n = 1'b0;
        rd_cycles(10);
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
        rd_cycles(2);
        t_reset_state();
        t_low_flags_ignored();
        t_arm_stream("R3", 1'b0);
        t_overflow();
        t_resync();
        t_arm_stream("R9", 1'b0);
        t_underflow();
        t_resync();
        t_group();
        t_resync();
        group_mode = 1'b0;
        rd_cycles(5);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule